// File: doc/BRIEF.md
# Register-Driven I2C Master Engine

This block is a single-master I2C engine that software operates through four 32-bit registers. Software picks one of several bus ports and a bus rate, loads up to four outgoing bytes into a data word, then writes a command naming the target's 7-bit address, the transfer direction, a byte count and how the transfer should end. The engine produces the START, address, data, acknowledge and STOP sequences on open-drain clock and data lines for the selected port.

Read data returns through the same data word in groups of up to four bytes. A ready flag in the status register marks each group, and the engine holds the clock low until software reads the word. A command may end with STOP, or it may park the bus in a wait phase with the clock held low so the next command opens with a repeated START. This lets a register-offset write be chained to a read. A target that does not acknowledge sets a sticky error flag, and the engine releases the bus with a STOP.

The controller has seven states. `ST_IDLE` goes to `ST_START` on launch. `ST_START` goes to `ST_SHIFT` once the start condition is on the bus. `ST_SHIFT` goes to `ST_ACK` after eight bits. `ST_ACK` then does one of four things. It goes back to `ST_SHIFT` for the next byte. It goes to `ST_HOLD` when a read word is full. It goes to `ST_STOP` on a NAK or at the end of a transfer that ends with a stop. It goes to `ST_WAIT` at the end of a transfer that ends with a wait. `ST_HOLD` returns to `ST_SHIFT` once software reads the data word. `ST_STOP` goes to `ST_IDLE`. `ST_WAIT` goes to `ST_START` on the next launch. Writing zero to the select register forces `ST_IDLE` from any state.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, and after any write of the value zero to the select register (offset 0), the engine is idle, status reads zero, the port field is zero and no clock or data line is driven.
- R2: The select register (offset 0) holds a port number in bits [2:0] and a rate code in bits [9:8]. Only the selected port's lines are ever driven. Port 0 drives nothing, and a launch while it is selected is ignored.
- R3: Rate codes 0, 1 and 2 (3 acts as 2) give each SCL high phase and low phase a length of two quarter periods. A quarter period is Q100, Q400 or Q1M system clocks.
- R4: A command-register write (offset 1) with bit 31 set launches a transfer. Status bit 0 (busy) then stays high until the engine is idle or in the wait phase. Command writes while busy are ignored.
- R5: Every transfer opens with a START and then sends an address byte. The address byte is the target address from command bits [7:1], followed by the direction bit from command bit 0 (1 = read). Bytes go out MSB first.
- R6: A write (direction 0) sends the count from command bits [15:8] (0 to 4) of bytes from the data register (offset 3). Bits [7:0] go first, then [15:8], and so on.
- R7: A read collects bytes little-endian into the data register. Status bit 2 rises when four bytes, or the final bytes, are present. Unfilled upper bytes read as zero. Until software reads offset 3, SCL is held low and no further byte is received.
- R8: During reads the master acknowledges every byte except the last, which it answers with NAK.
- R9: Command bit 16 selects the ending: 1 gives a STOP, and 0 gives a wait phase. In the wait phase, status bit 3 is set, busy is low, SCL is held low, and the next command opens with a repeated START.
- R10: A NAK on the address byte or on a written byte sets status bit 1. The engine stops shifting, issues a STOP and goes idle. Bit 1 stays set until the next launch clears it.
- R11: SDA changes while SCL is high only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of offset 3 acknowledges the data word) |
| addr | input | 2 | Register offset: 0 select, 1 command, 2 status, 3 data |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| sda_in | input | NPORT | Sensed data line level of each port |
| scl_oe | output | NPORT | Pull SCL low on each port when 1 |
| sda_oe | output | NPORT | Pull SDA low on each port when 1 |

## Verification
The assertions rely on software following the register protocol. The select register is rewritten only while the engine is not busy, write counts stay within four, and targets never stretch the clock, so sampled SDA is valid at the end of each high phase. The bench drives registers only through tasks that poll status before changing the select register. Its target model drives SDA only while SCL is low, and it drives SCL on one port only. Those tasks write a nonzero select value only when the engine is idle or waiting.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_STOP,
        ST_WAIT
    } st_e;

    localparam logic [1:0] RA_SEL  = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam int CMD_RD   = 0;
    localparam int CMD_TGT  = 1;
    localparam int CMD_CNT  = 8;
    localparam int CMD_STOP = 16;
    localparam int CMD_GO   = 31;
    localparam int SEL_RATE = 8;

endpackage

// File: rtl/i2c_cmd_qtick.sv
module i2c_cmd_qtick #(
    parameter int Q100 = 125,
    parameter int Q400 = 31,
    parameter int Q1M  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int QMAX = (Q100 > Q400) ? ((Q100 > Q1M) ? Q100 : Q1M)
                                        : ((Q400 > Q1M) ? Q400 : Q1M);
    localparam int CW = $clog2(QMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (rate)
            2'd0:    lim = CW'(Q100);
            2'd1:    lim = CW'(Q400);
            default: lim = CW'(Q1M);
        endcase
    end

    assign tick = (cnt_q >= lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr||tick) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_cmd_fanout.sv
module i2c_cmd_fanout #(
    parameter int NPORT = 8,
    parameter int PW    = 3
) (
    input  logic [PW-1:0]    port,
    input  logic             scl_q,
    input  logic             sda_q,
    output logic [NPORT-1:0] scl_oe,
    output logic [NPORT-1:0] sda_oe
);
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        if (i == 0) begin : g_off
            assign scl_oe[i] = 1'b0;
            assign sda_oe[i] = 1'b0;
        end else begin : g_on
            assign scl_oe[i] = (port == PW'(i)) && !scl_q;
            assign sda_oe[i] = (port == PW'(i)) && !sda_q;
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int Q100  = 125,
    parameter int Q400  = 31,
    parameter int Q1M   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NPORT-1:0] sda_in,
    output logic [NPORT-1:0] scl_oe,
    output logic [NPORT-1:0] sda_oe
);
    localparam int PW = $clog2(NPORT);

    st_e           state_q;
    logic [1:0]    phase_q;
    logic [PW-1:0] port_q;
    logic [1:0]    rate_q;
    logic          rd_q, stop_q, is_addr_q, nak_q, rdy_q;
    logic [6:0]    tgt_q;
    logic [7:0]    left_q, sh_q;
    logic [1:0]    idx_q;
    logic [2:0]    bit_q;
    logic [31:0]   tx_q, rx_q;
    logic          scl_q, sda_q, scl_n, sda_n;
    logic          tick, adv, busy, launch, sel_zero, sda_s;
    logic [1:0]    nidx;

    assign busy     = !(state_q inside {ST_IDLE, ST_WAIT});
    assign launch   = wr_en && addr == RA_CMD && wdata[CMD_GO] && !busy && port_q != '0;
    assign sel_zero = wr_en && addr == RA_SEL && wdata == 32'd0;
    assign adv      = tick && phase_q == 2'd3;
    assign sda_s    = sda_in[port_q];
    assign nidx     = idx_q + 2'd1;

    i2c_cmd_qtick #(.Q100(Q100), .Q400(Q400), .Q1M(Q1M)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(launch), .rate(rate_q), .tick(tick)
    );

    i2c_cmd_fanout #(.NPORT(NPORT), .PW(PW)) u_fan (
        .port(port_q), .scl_q(scl_q), .sda_q(sda_q), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_comb begin
        unique case (addr)
            RA_SEL:  rdata = 32'(port_q) | (32'(rate_q) << SEL_RATE);
            RA_CMD:  rdata = 32'd0;
            RA_STAT: rdata = {28'd0, state_q == ST_WAIT, rdy_q, nak_q, busy};
            default: rdata = rx_q;
        endcase
    end

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  phase_q <= '0;  port_q <= '0;  rate_q <= '0;
            rd_q <= 1'b0;  stop_q <= 1'b0;  is_addr_q <= 1'b0;  nak_q <= 1'b0;
            rdy_q <= 1'b0;  tgt_q <= '0;  left_q <= '0;  sh_q <= '0;
            idx_q <= '0;  bit_q <= '0;  tx_q <= '0;  rx_q <= '0;
        end else begin
            if (state_q inside {ST_START, ST_SHIFT, ST_ACK, ST_STOP}) begin
                if (tick) phase_q <= phase_q + 2'd1;
            end else begin
                phase_q <= '0;
            end
            if (wr_en && addr == RA_DATA) tx_q <= wdata;
            if (rd_en && addr == RA_DATA) rdy_q <= 1'b0;
            if (wr_en && addr == RA_SEL && !busy) begin
                port_q <= wdata[PW-1:0];
                rate_q <= wdata[SEL_RATE +: 2];
            end

            unique case (state_q)
                ST_START: if (adv) begin
                    sh_q <= {tgt_q, rd_q};  is_addr_q <= 1'b1;
                    bit_q <= '0;  state_q <= ST_SHIFT;
                end
                ST_SHIFT: if (adv) begin
                    sh_q  <= {sh_q[6:0], sda_s};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) state_q <= ST_ACK;
                end
                ST_ACK: if (adv) begin
                    if (is_addr_q || !rd_q) begin
                        if (sda_s) begin
                            nak_q <= 1'b1;  state_q <= ST_STOP;
                        end else if (is_addr_q) begin
                            is_addr_q <= 1'b0;  idx_q <= '0;
                            if (left_q == 8'd0)  state_q <= stop_q ? ST_STOP : ST_WAIT;
                            else begin
                                if (!rd_q) sh_q <= tx_q[7:0];
                                state_q <= ST_SHIFT;
                            end
                        end else if (left_q == 8'd1) begin
                            left_q <= '0;  state_q <= stop_q ? ST_STOP : ST_WAIT;
                        end else begin
                            left_q <= left_q - 8'd1;  idx_q <= nidx;
                            sh_q <= tx_q[{nidx, 3'b000} +: 8];
                            state_q <= ST_SHIFT;
                        end
                    end else begin
                        rx_q[{idx_q, 3'b000} +: 8] <= sh_q;
                        left_q <= left_q - 8'd1;  idx_q <= nidx;
                        if (left_q == 8'd1) begin
                            rdy_q <= 1'b1;  state_q <= stop_q ? ST_STOP : ST_WAIT;
                        end else if (idx_q == 2'd3) begin
                            rdy_q <= 1'b1;  state_q <= ST_HOLD;
                        end else begin
                            state_q <= ST_SHIFT;
                        end
                    end
                end
                ST_HOLD: if (!rdy_q) begin
                    rx_q <= '0;  idx_q <= '0;  state_q <= ST_SHIFT;
                end
                ST_STOP: if (adv) state_q <= ST_IDLE;
                ST_IDLE, ST_WAIT: ;
                default: state_q <= ST_IDLE;
            endcase

            if (launch) begin
                rd_q   <= wdata[CMD_RD];    tgt_q  <= wdata[CMD_TGT +: 7];
                left_q <= wdata[CMD_CNT +: 8];  stop_q <= wdata[CMD_STOP];
                nak_q  <= 1'b0;  rdy_q <= 1'b0;  rx_q <= '0;  idx_q <= '0;
                phase_q <= '0;  state_q <= ST_START;
            end
            if (sel_zero) begin
                state_q <= ST_IDLE;  port_q <= '0;  rate_q <= '0;
                nak_q <= 1'b0;  rdy_q <= 1'b0;  phase_q <= '0;
            end
        end
    end

    // line levels per state and phase: SCL high in phases 2-3, SDA moves in phase 1
    always_comb begin
        scl_n = 1'b1;
        sda_n = sda_q;
        unique case (state_q)
            ST_IDLE:  sda_n = 1'b1;
            ST_START: begin
                scl_n = phase_q[1];
                if (phase_q == 2'd1 || phase_q == 2'd2) sda_n = 1'b1;
                else if (phase_q == 2'd3)               sda_n = 1'b0;
            end
            ST_SHIFT: begin
                scl_n = phase_q[1];
                if (phase_q != 2'd0) sda_n = (rd_q && !is_addr_q) ? 1'b1 : sh_q[7];
            end
            ST_ACK: begin
                scl_n = phase_q[1];
                if (phase_q != 2'd0) sda_n = (is_addr_q || !rd_q) ? 1'b1 : (left_q == 8'd1);
            end
            ST_HOLD, ST_WAIT: scl_n = 1'b0;
            ST_STOP: begin
                scl_n = phase_q[1];
                if (phase_q != 2'd0) sda_n = (phase_q == 2'd3);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_n;
            sda_q <= sda_n;
        end
    end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
    import i2c_cmd_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int PW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input st_e              state_q,
    input logic [PW-1:0]    port_q,
    input logic             scl_q,
    input logic             sda_q,
    input logic             nak_q,
    input logic             rdy_q,
    input logic             rd_q,
    input logic [6:0]       tgt_q,
    input logic             busy,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [NPORT-1:0] scl_oe,
    input logic [NPORT-1:0] sda_oe
);
    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        port_q == '0 |-> (scl_oe == '0 && sda_oe == '0)); // R2

    AST_HIGH_SDA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && sda_q != $past(sda_q))
        |-> ($past(state_q) inside {ST_START, ST_STOP, ST_IDLE})); // R11

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == RA_CMD) |=> $stable(tgt_q)); // R4

    AST_NAK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nak_q) |-> state_q == ST_STOP); // R10

    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> !scl_q); // R7

    AST_RDY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> rd_q); // R7

    AST_WAIT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> (!scl_q && !busy)); // R9
endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .port_q(port_q),
    .scl_q(scl_q), .sda_q(sda_q), .nak_q(nak_q), .rdy_q(rdy_q), .rd_q(rd_q),
    .tgt_q(tgt_q), .busy(busy), .wr_en(wr_en), .addr(addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_cmd_master_test.sv
module i2c_cmd_master_test;
    localparam int NP = 8;
    localparam int PSEL = 3;
    localparam logic [6:0] SLV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] sda_in, scl_oe, sda_oe;

    always #10 clk = ~clk;

    i2c_cmd_master #(.NPORT(NP), .Q100(8), .Q400(4), .Q1M(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    logic slv_sda = 1'b1;
    wire scl_bus = !scl_oe[PSEL];
    wire sda_bus = !sda_oe[PSEL] && slv_sda;
    assign sda_in = {NP{sda_bus}};

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    int bytes_seen = 0, starts = 0, stops = 0, macks = 0, mnaks = 0;
    int hcnt = 0, hi_len = 0, hedges = 0, stray = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor: every byte the target sees is popped and compared
    task automatic sb_take(input logic [7:0] b);
        bytes_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected byte", b, 0);
        else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(b == e, "R5/R6 bus byte", b, e);
        end
    endtask

    // target model
    logic live = 1'b0, in_addr = 1'b0, tx_mode = 1'b0, matched = 1'b0, mack = 1'b1;
    logic [7:0] sr = '0, txb = '0;
    int pcnt = 0, tx_idx = 0;

    always @(negedge sda_bus) if (scl_bus) begin
        starts++; live = 1; pcnt = 0; in_addr = 1; tx_mode = 0; matched = 0; slv_sda = 1;
    end
    always @(posedge sda_bus) if (scl_bus && live) begin
        stops++; live = 0; pcnt = 0; matched = 0; slv_sda = 1;
    end
    always @(posedge scl_bus) if (live) begin
        if (pcnt < 8) sr = {sr[6:0], sda_bus};
        else mack = sda_bus;
        pcnt++;
    end
    always @(negedge scl_bus) if (live) begin
        if (pcnt == 8) begin
            if (in_addr) begin
                sb_take(sr);
                matched = (sr[7:1] == SLV); tx_mode = sr[0]; tx_idx = 0;
                slv_sda = matched ? 1'b0 : 1'b1;
            end else if (!tx_mode) begin
                sb_take(sr); slv_sda = 1'b0;
            end else slv_sda = 1'b1;
        end else if (pcnt == 9) begin
            pcnt = 0;
            if (tx_mode && !in_addr) begin
                if (mack) mnaks++; else macks++;
            end
            if (matched && tx_mode && (in_addr || !mack)) begin
                txb = 8'hA0 + 8'(tx_idx); tx_idx++; slv_sda = txb[7];
            end else slv_sda = 1'b1;
            in_addr = 0;
        end else if (pcnt >= 1 && matched && tx_mode && !in_addr) begin
            slv_sda = txb[7-pcnt];
        end
    end

    logic pscl = 1'b1, psda = 1'b1;
    always @(negedge clk) begin
        if (scl_bus) hcnt++;
        else begin
            if (hcnt > 0) hi_len = hcnt;
            hcnt = 0;
        end
        if (pscl && scl_bus && psda != sda_bus) hedges++;
        if (((scl_oe | sda_oe) & ~(NP'(1) << PSEL)) != '0) stray++;
        pscl = scl_bus; psda = sda_bus;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask
    task automatic poll(input logic [31:0] mask, input logic [31:0] val, input string tag);
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, s);
            if ((s & mask) == val) return;
        end
        chk(1'b0, tag, s, val);
    endtask
    function automatic logic [31:0] cmd(input bit go, input bit stop, input int cnt,
                                        input logic [6:0] t, input bit r);
        return (32'(go) << 31) | (32'(stop) << 16) | (32'(cnt & 255) << 8) | (32'(t) << 1) | 32'(r);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int b0, s0, p0, h0, m0, n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd2, s);  chk(s == 0, "R1 status after reset", s, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines after reset", {scl_oe, sda_oe}, 0);

        wr(2'd0, 32'h0000_0003);
        rd(2'd0, s);  chk(s == 32'h3, "R2 select readback", s, 3);

        // R6 write three bytes with stop
        exp_q.push_back(8'hA0); exp_q.push_back(8'h11); exp_q.push_back(8'h22); exp_q.push_back(8'h33);
        s0 = stops; h0 = hedges;
        wr(2'd3, 32'h0033_2211);
        wr(2'd1, cmd(1, 1, 3, SLV, 0));
        rd(2'd2, s);  chk(s[0] == 1'b1, "R4 busy after launch", s, 1);
        poll(32'h1, 32'h0, "R4 busy falls");
        rd(2'd2, s);  chk(s == 0, "R6 clean status", s, 0);
        chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
        chk(stops == s0 + 1, "R9 stop ending", stops, s0 + 1);
        chk(hi_len == 16, "R3 rate0 high time", hi_len, 16);
        chk(hedges == h0 + 2, "R11 only start and stop edges", hedges - h0, 2);

        // R4 second command while busy is ignored
        exp_q.push_back(8'hA0); exp_q.push_back(8'h5A);
        b0 = bytes_seen;
        wr(2'd3, 32'h0000_005A);
        wr(2'd1, cmd(1, 1, 1, SLV, 0));
        wr(2'd1, cmd(1, 1, 2, 7'h51, 0));
        poll(32'h1, 32'h0, "R4 busy falls");
        chk(bytes_seen == b0 + 2, "R4 ignored command", bytes_seen - b0, 2);

        // R7 R8 read six bytes
        exp_q.push_back(8'hA1);
        m0 = macks; n0 = mnaks;
        wr(2'd1, cmd(1, 1, 6, SLV, 1));
        poll(32'h4, 32'h4, "R7 first word ready");
        rd(2'd2, s);  chk(s[0] == 1'b1, "R7 busy while held", s, 1);
        rd(2'd3, s);  chk(s == 32'hA3A2_A1A0, "R7 first word", s, 32'hA3A2A1A0);
        poll(32'h4, 32'h4, "R7 second word ready");
        rd(2'd3, s);  chk(s == 32'h0000_A5A4, "R7 partial word", s, 32'hA5A4);
        poll(32'h1, 32'h0, "R7 busy falls");
        chk(macks == m0 + 5, "R8 acked bytes", macks - m0, 5);
        chk(mnaks == n0 + 1, "R8 final nak", mnaks - n0, 1);

        // R9 wait phase then repeated start
        exp_q.push_back(8'hA0); exp_q.push_back(8'h77); exp_q.push_back(8'hA1);
        s0 = stops; p0 = starts;
        wr(2'd3, 32'h0000_0077);
        wr(2'd1, cmd(1, 0, 1, SLV, 0));
        poll(32'h8, 32'h8, "R9 wait phase");
        rd(2'd2, s);  chk(s == 32'h8, "R9 wait status", s, 8);
        chk(scl_oe[PSEL] == 1'b1, "R9 scl held low", scl_oe[PSEL], 1);
        chk(stops == s0, "R9 no stop in wait", stops - s0, 0);
        wr(2'd1, cmd(1, 1, 2, SLV, 1));
        poll(32'h5, 32'h4, "R9 chained read done");
        rd(2'd3, s);  chk(s == 32'h0000_A1A0, "R7 chained read word", s, 32'hA1A0);
        chk(starts == p0 + 2 && stops == s0 + 1, "R9 repeated start", starts - p0, 2);

        // R10 address nak
        exp_q.push_back(8'h44);
        s0 = stops;
        wr(2'd1, cmd(1, 1, 1, 7'h22, 0));
        poll(32'h1, 32'h0, "R10 busy falls");
        rd(2'd2, s);  chk(s == 32'h2, "R10 nak status", s, 2);
        chk(stops == s0 + 1, "R10 stop after nak", stops - s0, 1);
        chk(scl_oe == 0 && sda_oe == 0, "R10 lines released", {scl_oe, sda_oe}, 0);
        exp_q.push_back(8'hA0);
        wr(2'd1, cmd(1, 1, 0, SLV, 0));
        rd(2'd2, s);  chk(s[1] == 1'b0, "R10 launch clears nak", s, 1);
        poll(32'h1, 32'h0, "R5 address only done");
        chk(exp_q.size() == 0, "R5 address byte", exp_q.size(), 0);

        // R2 port 0 disables
        b0 = bytes_seen;
        wr(2'd0, 32'h0000_0200);
        wr(2'd1, cmd(1, 1, 1, SLV, 0));
        rd(2'd2, s);  chk(s[0] == 1'b0, "R2 port0 launch ignored", s, 0);
        repeat (100) @(negedge clk);
        chk(bytes_seen == b0, "R2 port0 no bus activity", bytes_seen - b0, 0);

        // R3 fastest rate
        wr(2'd0, 32'h0000_0203);
        exp_q.push_back(8'hA0); exp_q.push_back(8'h3C);
        wr(2'd3, 32'h0000_003C);
        wr(2'd1, cmd(1, 1, 1, SLV, 0));
        poll(32'h1, 32'h0, "R3 busy falls");
        chk(hi_len == 4, "R3 rate2 high time", hi_len, 4);
        chk(stray == 0, "R2 unselected ports quiet", stray, 0);

        // R1 select zero from wait phase
        exp_q.push_back(8'hA0); exp_q.push_back(8'h01);
        wr(2'd3, 32'h0000_0001);
        wr(2'd1, cmd(1, 0, 1, SLV, 0));
        poll(32'h8, 32'h8, "R1 reach wait");
        wr(2'd0, 32'h0);
        rd(2'd2, s);  chk(s == 0, "R1 select zero status", s, 0);
        @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R1 select zero lines", {scl_oe, sda_oe}, 0);
        rd(2'd0, s);  chk(s == 0, "R1 port cleared", s, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule